// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the control-register front end of a fractional-N frequency synthesizer. A host drives three serial wires (data, clock and a write strobe) plus a fourth enable that steers bits to an auxiliary path. The serial wires are asynchronous to the block clock. They pass through multi-flop synchronizers, and all actions follow edges detected on the synchronized copies. A 21-bit frame is shifted in. Its last bit chooses which holding register receives the frame when the strobe rises. The counter register holds the reference divider, the main divider, the swallow count and the prescaler-bypass flag. The fractional register holds the 18-bit modulator word.

An 8-bit enhancement word travels the same wires while the steering enable is high. It is double buffered: the shifted bits reach the working buffer only when that enable falls. The buffered bits take effect only while an active-low enhancement input is held low. Those bits select power-down, continuous counter load, lock-detect disable and a test-output selector. The selector picks one of three internal signals, and a fixed priority plus an error flag cover illegal combinations. A direct-mode input makes the divider fields and the fractional word come from parallel pins, and serial frame loads are ignored while it is set.

Top module: `synth_prog_if`

## Requirements
- R1: While both the write strobe and the enhancement write enable are low, each rising edge of the synchronized serial clock shifts the synchronized data bit into a 21-bit primary register, so the first bit sent ends up most significant.
- R2: On a rising edge of the write strobe, a last-sent bit of 0 copies the primary register into the counter register and a 1 copies it into the fractional register; the other holding register keeps its value.
- R3: Counter frame order, first bit sent to last: R[5], R[4], M[8], M[7], prescaler-bypass, M[6] down to M[0], R[3] down to R[0], A[3] down to A[0], then the routing bit 0.
- R4: Fractional frame order, first bit sent to last: K[17] down to K[0], two reserved bits, then the routing bit 1.
- R5: While the enhancement write enable is high (and the strobe low), serial clock edges shift bits into an 8-bit enhancement shifter, with the first bit sent becoming enhancement bit 0. The working buffer is updated only on the falling edge of that enable.
- R6: While enh_en_n is high, pwr_down, cnt_load, ld_disable and sel_err are 0 and tst_sel is 0, whatever the buffer holds.
- R7: tst_sel encodes the test-output source as 0 none, 1 divided-VCO (bit 2), 2 modulus select (bit 5), 3 divided reference (bit 6), with priority bit 2 over bit 5 over bit 6. sel_err is 1 when more than one of bits 2, 4, 5, 6 is set.
- R8: Enhancement bit 3 drives pwr_down, bit 4 drives cnt_load and bit 7 drives ld_disable.
- R9: While dir_mode is high, the divider, bypass and fractional outputs follow the dir_* pins, and strobe edges change neither holding register.
- R10: Shifting an enhancement word does not disturb the primary register.
- R11: After reset, all holding registers and the enhancement buffer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_stb | input | 1 | Frame write strobe (asynchronous) |
| enh_wr | input | 1 | Enhancement write enable (asynchronous) |
| enh_en_n | input | 1 | Active-low enable of the enhancement bits |
| dir_mode | input | 1 | Selects the parallel pins as field source |
| dir_r | input | 6 | Parallel reference divider value |
| dir_m | input | 9 | Parallel main divider value |
| dir_a | input | 4 | Parallel swallow count |
| dir_pre_byp | input | 1 | Parallel prescaler-bypass flag |
| dir_k | input | 18 | Parallel fractional word |
| r_div | output | 6 | Reference divider value |
| m_div | output | 9 | Main divider value |
| a_cnt | output | 4 | Swallow count |
| pre_byp | output | 1 | Prescaler bypass |
| k_frac | output | 18 | Fractional word |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Continuous counter load request |
| ld_disable | output | 1 | Lock-detect disable |
| tst_sel | output | 2 | Test-output source select |
| sel_err | output | 1 | Illegal combination of exclusive enhancement bits |

## Verification
The bench scrambles the frame order. A design that reverses the shift direction or misplaces one field returns the wrong divider values, and random fields drawn across the full widths expose these errors. It alternates counter and fractional frames to catch a routing bit sampled from the wrong end, which writes both registers or the wrong one. It checks the enhancement outputs after shifting but before the enable falls, and again after it falls, to catch a buffer that is not double buffered. It sets several exclusive bits together to catch a wrong priority order or a missing error flag. It sends frames during direct mode and shifts an enhancement word between a frame and its strobe, to catch serial loads that leak through or a primary register that the enhancement traffic corrupts.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int FRAME_W = 21;
  localparam int ENH_W   = 8;
  localparam int R_W     = 6;
  localparam int M_W     = 9;
  localparam int A_W     = 4;
  localparam int K_W     = 18;

  // enhancement bit positions (position = order of arrival, first bit is 0)
  localparam int EB_FP    = 2;
  localparam int EB_PDN   = 3;
  localparam int EB_LOAD  = 4;
  localparam int EB_MSEL  = 5;
  localparam int EB_FC    = 6;
  localparam int EB_LDDIS = 7;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           pre_byp;
  } cnt_fields_t;

  typedef enum logic [1:0] {
    TST_NONE = 2'd0,
    TST_FP   = 2'd1,
    TST_MSEL = 2'd2,
    TST_FC   = 2'd3
  } tst_sel_e;

  // counter frame: primary bit 20 is the first bit sent, bit 0 the routing bit
  function automatic cnt_fields_t frame_to_cnt(input logic [FRAME_W-1:0] w);
    cnt_fields_t f;
    f.r       = {w[20], w[19], w[8:5]};
    f.m       = {w[18], w[17], w[15:9]};
    f.pre_byp = w[16];
    f.a       = w[4:1];
    return f;
  endfunction

  function automatic logic [K_W-1:0] frame_to_k(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-1 -: K_W];
  endfunction

  function automatic tst_sel_e pick_test(input logic [ENH_W-1:0] e);
    if (e[EB_FP])        return TST_FP;
    else if (e[EB_MSEL]) return TST_MSEL;
    else if (e[EB_FC])   return TST_FC;
    else                 return TST_NONE;
  endfunction

  function automatic logic excl_clash(input logic [ENH_W-1:0] e);
    logic [2:0] n;
    n = 3'(e[EB_FP]) + 3'(e[EB_LOAD]) + 3'(e[EB_MSEL]) + 3'(e[EB_FC]);
    return n > 3'd1;
  endfunction
endpackage

// File: rtl/synth_sync_edge.sv
module synth_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[DEPTH-2:0], async_in[i]};
    end
    assign lvl[i]  = sh[STAGES-1];
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/synth_shreg.sv
module synth_shreg #(
  parameter int W        = 8,
  parameter bit FIRST_HI = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  if (FIRST_HI) begin : g_left
    assign nxt = {q[W-2:0], din};
  end else begin : g_right
    assign nxt = {din, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= nxt;
  end
endmodule

// File: rtl/synth_enh_decode.sv
module synth_enh_decode
  import synth_prog_pkg::*;
(
  input  logic [ENH_W-1:0] enh_q,
  input  logic             enh_en_n,
  output logic             pwr_down,
  output logic             cnt_load,
  output logic             ld_disable,
  output logic [1:0]       tst_sel,
  output logic             sel_err
);
  logic [ENH_W-1:0] act;
  tst_sel_e         pick;

  assign act        = enh_en_n ? '0 : enh_q;
  assign pick       = pick_test(act);
  assign tst_sel    = pick;
  assign sel_err    = excl_clash(act);
  assign pwr_down   = act[EB_PDN];
  assign cnt_load   = act[EB_LOAD];
  assign ld_disable = act[EB_LDDIS];
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_stb,
  input  logic        enh_wr,
  input  logic        enh_en_n,
  input  logic        dir_mode,
  input  logic [5:0]  dir_r,
  input  logic [8:0]  dir_m,
  input  logic [3:0]  dir_a,
  input  logic        dir_pre_byp,
  input  logic [17:0] dir_k,
  output logic [5:0]  r_div,
  output logic [8:0]  m_div,
  output logic [3:0]  a_cnt,
  output logic        pre_byp,
  output logic [17:0] k_frac,
  output logic        pwr_down,
  output logic        cnt_load,
  output logic        ld_disable,
  output logic [1:0]  tst_sel,
  output logic        sel_err
);
  localparam int CH_SCLK = 0;
  localparam int CH_DAT  = 1;
  localparam int CH_STB  = 2;
  localparam int CH_EWR  = 3;
  localparam int N_CH    = 4;

  logic [N_CH-1:0] s_lvl, s_rise, s_fall;

  synth_sync_edge #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({enh_wr, ser_stb, ser_dat, ser_clk}),
    .lvl      (s_lvl),
    .rise     (s_rise),
    .fall     (s_fall)
  );

  // named internal events
  logic pri_shift, enh_shift, cnt_wr, k_wr, enh_cap;
  logic [FRAME_W-1:0] pri_q;
  logic [ENH_W-1:0]   esh_q;

  assign pri_shift = s_rise[CH_SCLK] & ~s_lvl[CH_STB] & ~s_lvl[CH_EWR];
  assign enh_shift = s_rise[CH_SCLK] & ~s_lvl[CH_STB] &  s_lvl[CH_EWR];
  assign cnt_wr    = s_rise[CH_STB] & ~dir_mode & ~pri_q[0];
  assign k_wr      = s_rise[CH_STB] & ~dir_mode &  pri_q[0];
  assign enh_cap   = s_fall[CH_EWR];

  synth_shreg #(.W(FRAME_W), .FIRST_HI(1'b1)) u_pri (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (pri_shift),
    .din   (s_lvl[CH_DAT]),
    .q     (pri_q)
  );

  synth_shreg #(.W(ENH_W), .FIRST_HI(1'b0)) u_esh (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (enh_shift),
    .din   (s_lvl[CH_DAT]),
    .q     (esh_q)
  );

  cnt_fields_t      cnt_q;
  logic [K_W-1:0]   k_q;
  logic [ENH_W-1:0] enh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      k_q   <= '0;
      enh_q <= '0;
    end else begin
      if (cnt_wr)  cnt_q <= frame_to_cnt(pri_q);
      if (k_wr)    k_q   <= frame_to_k(pri_q);
      if (enh_cap) enh_q <= esh_q;
    end
  end

  assign r_div   = dir_mode ? dir_r       : cnt_q.r;
  assign m_div   = dir_mode ? dir_m       : cnt_q.m;
  assign a_cnt   = dir_mode ? dir_a       : cnt_q.a;
  assign pre_byp = dir_mode ? dir_pre_byp : cnt_q.pre_byp;
  assign k_frac  = dir_mode ? dir_k       : k_q;

  synth_enh_decode u_dec (
    .enh_q      (enh_q),
    .enh_en_n   (enh_en_n),
    .pwr_down   (pwr_down),
    .cnt_load   (cnt_load),
    .ld_disable (ld_disable),
    .tst_sel    (tst_sel),
    .sel_err    (sel_err)
  );

  logic unused_bits;
  assign unused_bits = ^{s_lvl[CH_SCLK], s_rise[CH_DAT], s_rise[CH_EWR],
                         s_fall[CH_SCLK], s_fall[CH_DAT], s_fall[CH_STB]};
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pri_shift,
  input logic        enh_shift,
  input logic        cnt_wr,
  input logic        k_wr,
  input logic        enh_cap,
  input logic        dir_mode,
  input logic        enh_en_n,
  input logic [19:0] cnt_q,
  input logic [17:0] k_q,
  input logic [7:0]  enh_q,
  input logic [1:0]  tst_sel,
  input logic        pwr_down,
  input logic        cnt_load,
  input logic        ld_disable,
  input logic        sel_err
);
  // R2: one frame lands in exactly one holding register
  a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_wr && k_wr));

  // R9: direct mode blocks every holding-register write
  a_r9_direct_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dir_mode |-> (!cnt_wr && !k_wr));

  // R2: counter register changes only after a counter write
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(cnt_q));

  // R2: fractional register changes only after a fractional write
  a_r2_k_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !k_wr |=> $stable(k_q));

  // R5: enhancement buffer changes only on capture
  a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_cap |=> $stable(enh_q));

  // R10: a serial clock edge feeds only one shifter
  a_r10_one_shifter: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_shift && enh_shift));

  // R6: outputs quiet while the enhancement enable is inactive
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    enh_en_n |-> (tst_sel == 2'd0 && !pwr_down && !cnt_load && !ld_disable && !sel_err));
endmodule

bind synth_prog_if synth_prog_chk u_chk (.*);

// File: tb/tb_synth_prog_if.sv
`timescale 1ns/1ps
module tb_synth_prog_if;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0, enh_wr = 1'b0;
  logic enh_en_n = 1'b1, dir_mode = 1'b0;
  logic [5:0] dir_r = '0;
  logic [8:0] dir_m = '0;
  logic [3:0] dir_a = '0;
  logic dir_pre_byp = 1'b0;
  logic [17:0] dir_k = '0;
  logic [5:0] r_div;
  logic [8:0] m_div;
  logic [3:0] a_cnt;
  logic pre_byp;
  logic [17:0] k_frac;
  logic pwr_down, cnt_load, ld_disable, sel_err;
  logic [1:0] tst_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the holding registers
  logic [5:0] e_r = '0;
  logic [8:0] e_m = '0;
  logic [3:0] e_a = '0;
  logic e_p = 1'b0;
  logic [17:0] e_k = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_if dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] mk_cnt(input logic [5:0] r, input logic [8:0] m,
                                         input logic [3:0] a, input logic p);
    logic [20:0] w;
    w = '0;
    w[20] = r[5]; w[19] = r[4]; w[18] = m[8]; w[17] = m[7]; w[16] = p;
    for (int i = 0; i < 7; i++) w[9+i] = m[i];
    for (int i = 0; i < 4; i++) w[5+i] = r[i];
    for (int i = 0; i < 4; i++) w[1+i] = a[i];
    return w;
  endfunction

  function automatic logic [20:0] mk_k(input logic [17:0] k);
    return {k, 2'b00, 1'b1};
  endfunction

  function automatic logic [1:0] exp_tst(input logic [7:0] e);
    if (e[2]) return 2'd1;
    if (e[5]) return 2'd2;
    if (e[6]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic exp_err(input logic [7:0] e);
    int n;
    n = int'(e[2]) + int'(e[4]) + int'(e[5]) + int'(e[6]);
    return n > 1;
  endfunction

  task automatic send_bit(input logic b);
    ser_dat = b; tick(4);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0;
  endtask

  task automatic shift_frame(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    tick(2); ser_stb = 1'b1; tick(4); ser_stb = 1'b0; tick(6);
  endtask

  task automatic shift_enh(input logic [7:0] e);
    enh_wr = 1'b1; tick(4);
    for (int i = 0; i < 8; i++) send_bit(e[i]);
    tick(6);
  endtask

  task automatic close_enh();
    enh_wr = 1'b0; tick(6);
  endtask

  task automatic check_fields(input string req);
    chk({req, " r_div"}, 32'(r_div), 32'(e_r));
    chk({req, " m_div"}, 32'(m_div), 32'(e_m));
    chk({req, " a_cnt"}, 32'(a_cnt), 32'(e_a));
    chk({req, " pre_byp"}, 32'(pre_byp), 32'(e_p));
    chk({req, " k_frac"}, 32'(k_frac), 32'(e_k));
  endtask

  task automatic check_enh(input string req, input logic [7:0] e);
    chk({req, " tst_sel"}, 32'(tst_sel), 32'(exp_tst(e)));
    chk({req, " sel_err"}, 32'(sel_err), 32'(exp_err(e)));
    chk({req, " pwr_down"}, 32'(pwr_down), 32'(e[3]));
    chk({req, " cnt_load"}, 32'(cnt_load), 32'(e[4]));
    chk({req, " ld_disable"}, 32'(ld_disable), 32'(e[7]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] eb;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R11 reset state
    check_fields("R11");
    enh_en_n = 1'b0; tick(1);
    check_enh("R11", 8'h00);

    // R1 R2 R3 R4 random frames, counter and fractional interleaved
    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(0, 1) == 0) begin
        e_r = 6'($urandom); e_m = 9'($urandom); e_a = 4'($urandom); e_p = 1'($urandom);
        shift_frame(mk_cnt(e_r, e_m, e_a, e_p));
        strobe();
        check_fields("R1 R2 R3 counter");
      end else begin
        e_k = 18'($urandom);
        shift_frame(mk_k(e_k));
        strobe();
        check_fields("R1 R2 R4 fractional");
      end
    end

    // R3 directed corners: all ones, then single fields
    e_r = 6'h3F; e_m = 9'h1FF; e_a = 4'hF; e_p = 1'b1;
    shift_frame(mk_cnt(e_r, e_m, e_a, e_p)); strobe();
    check_fields("R3 all ones");
    e_r = 6'h21; e_m = 9'h101; e_a = 4'h8; e_p = 1'b0;
    shift_frame(mk_cnt(e_r, e_m, e_a, e_p)); strobe();
    check_fields("R3 edge bits");
    // R4 corner
    e_k = 18'h20001;
    shift_frame(mk_k(e_k)); strobe();
    check_fields("R4 edge bits");

    // R5 double buffering: nothing changes until the enable falls
    shift_enh(8'b1000_1000);
    check_enh("R5 before capture", 8'h00);
    close_enh();
    check_enh("R5 R8 after capture", 8'b1000_1000);

    // R6 gating
    enh_en_n = 1'b1; tick(1);
    check_enh("R6 gated", 8'h00);
    enh_en_n = 1'b0; tick(1);
    check_enh("R6 ungated", 8'b1000_1000);

    // R7 priority and clash cases
    eb = 8'b0110_0100; shift_enh(eb); close_enh(); check_enh("R7 fp wins", eb);
    eb = 8'b0110_0000; shift_enh(eb); close_enh(); check_enh("R7 msel wins", eb);
    eb = 8'b0100_0000; shift_enh(eb); close_enh(); check_enh("R7 fc alone", eb);
    eb = 8'b0001_0000; shift_enh(eb); close_enh(); check_enh("R8 load alone", eb);
    eb = 8'b0101_0000; shift_enh(eb); close_enh(); check_enh("R7 load clash", eb);

    // R7 R8 random words with reserved bits zero
    for (int it = 0; it < 8; it++) begin
      eb = 8'($urandom) & 8'hFC;
      shift_enh(eb); close_enh();
      check_enh("R7 R8 random", eb);
    end

    // R10 enhancement traffic between frame and strobe
    e_r = 6'h15; e_m = 9'h0AA; e_a = 4'h5; e_p = 1'b1;
    shift_frame(mk_cnt(e_r, e_m, e_a, e_p));
    eb = 8'b1111_1100;
    shift_enh(eb); close_enh();
    strobe();
    check_fields("R10 primary kept");
    check_enh("R10 enh word", eb);

    // R9 direct mode
    dir_mode = 1'b1;
    dir_r = 6'h2A; dir_m = 9'h155; dir_a = 4'h9; dir_pre_byp = 1'b1; dir_k = 18'h2_ABCD;
    tick(1);
    chk("R9 dir r", 32'(r_div), 32'h2A);
    chk("R9 dir m", 32'(m_div), 32'h155);
    chk("R9 dir a", 32'(a_cnt), 32'h9);
    chk("R9 dir pre", 32'(pre_byp), 32'h1);
    chk("R9 dir k", 32'(k_frac), 32'h2ABCD);
    shift_frame(mk_cnt(6'h01, 9'h003, 4'h2, 1'b0)); strobe();
    shift_frame(mk_k(18'h00777)); strobe();
    chk("R9 pins hold r", 32'(r_div), 32'h2A);
    chk("R9 pins hold k", 32'(k_frac), 32'h2ABCD);
    dir_mode = 1'b0; tick(1);
    check_fields("R9 serial ignored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule